// File: doc/BRIEF.md
# Cascaded Interrupt Vector Generator

This block joins two eight-line interrupt resolvers into one sixteen-line controller. Lines 0 to 7 belong to the master and lines 8 to 15 belong to the slave. A pending request on the slave is passed to the master through the master's cascade input, line 2. The master drives one interrupt output toward the processor.

When the processor pulses its acknowledge strobe, the block settles the acknowledge in one pass. The master's winner is acknowledged first. If that winner is the cascade input, the slave's winner is then acknowledged. The block returns an 8-bit vector. The upper bits of the vector are the base of the controller that owns the winning line, and the low three bits are the line number within that controller. When no winner is found, line 7 of the controller that was asked is returned as a spurious code.

Each line is either edge or level triggered, as chosen by a per-controller trigger-select register. A fixed write mask on each register keeps some lines edge triggered at all times.

Top module: `cascade_vector_gen`

## Requirements
- R1: After reset, `cpuInt` and `vecValid` are low, and both trigger-select registers read 0, so every line is edge triggered.
- R2: Line n is served by the master when n < 8 and by the slave otherwise. The vector of an acknowledged line is {owner base, n mod 8}, where the base is `masterBase` or `slaveBase`.
- R3: The master's input 2 is asserted while the slave holds any pending request, with one cycle of lag. The master's input 2 is also asserted by a pending edge on external line 2. A win on master input 2 routes the acknowledge to the slave.
- R4: Within each controller the lowest pending line index wins. The master's input 2 ranks between master lines 1 and 3.
- R5: `cpuInt` is high exactly when the master has any pending input, including input 2. It is re-evaluated from the updated state after each acknowledge.
- R6: `ack` is a one-cycle strobe. On the clock edge that samples `ack`, `vector` is loaded and `vecValid` rises. `vecValid` stays high for that one cycle only.
- R7: An acknowledge with no master request returns {masterBase, 7} and clears nothing.
- R8: An acknowledge won by master input 2 while the slave has no pending line returns {slaveBase, 7}. It still clears the master's edge request on line 2.
- R9: When a line's trigger bit is 0, the line is edge triggered: a rising edge sets its request and an acknowledge of that line clears it. When the trigger bit is 1, the line is level triggered: the request follows the line and an acknowledge does not clear it.
- R10: If a new rising edge arrives on an edge-triggered line in the same cycle that the line is acknowledged, the line stays pending.
- R11: The trigger-select writes are masked with 0xF8 on the master and 0xDE on the slave. Masked bits read as 0, and the lines behind those bits stay edge triggered. `trigSel` = 0 selects the master register and 1 selects the slave register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | 16 | Interrupt request lines; bit n is line n |
| masterBase | input | 5 | Upper vector bits for master lines |
| slaveBase | input | 5 | Upper vector bits for slave lines |
| ack | input | 1 | Processor acknowledge strobe |
| trigWr | input | 1 | Trigger-select register write enable |
| trigSel | input | 1 | Target of the write: 0 master, 1 slave |
| trigData | input | 8 | Write data for the trigger-select register; 1 selects level trigger |
| cpuInt | output | 1 | Interrupt request to the processor |
| vecValid | output | 1 | One-cycle flag that marks `vector` as fresh |
| vector | output | 8 | Vector returned by the last acknowledge |
| trigMaster | output | 8 | Master trigger-select register |
| trigSlave | output | 8 | Slave trigger-select register |

## Verification
Two events can land on the same clock edge: the clearing of an edge request by an acknowledge, and a fresh rising edge on that same line. The bench provokes this by driving a new edge on line 4 in the cycle that acknowledges line 4. It counts the event as handled correctly if `cpuInt` stays high and a second acknowledge returns line 4 again. A second overlap is also covered: a cascade acknowledge that finds the slave empty after external line 2 fired. The bench judges it by the slave spurious vector, followed by `cpuInt` falling.

// File: rtl/cascade_vector_pkg.sv
package cascade_vector_pkg;
  // Strobes from the acknowledge sequencer to the datapath
  typedef struct packed {
    logic loadVec;    // capture a new vector
    logic useSlave;   // vector base and index come from the slave
    logic spurious;   // index is forced to the spurious line
    logic clrMaster;  // acknowledge the master winner
    logic clrSlave;   // acknowledge the slave winner
  } ackCmd_t;
endpackage

// File: rtl/cascade_resolver.sv
module cascade_resolver #(
  parameter int WIDTH = 8,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] req,
  output logic             hasWin,
  output logic [IW-1:0]    win
);
  // lowest index wins
  always_comb begin
    hasWin = |req;
    win = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (req[k]) win = IW'(k);
    end
  end
endmodule

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import cascade_vector_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack,
  input  logic          mHas,
  input  logic [IW-1:0] mWin,
  input  logic          sHas,
  output ackCmd_t       cmd,
  output logic          vecValid
);
  always_comb begin
    cmd = '0;
    cmd.loadVec = ack;
    if (ack) begin
      if (!mHas) begin
        cmd.spurious = 1'b1;
      end else begin
        cmd.clrMaster = 1'b1;
        if (mWin == IW'(CASC_LINE)) begin
          cmd.useSlave = 1'b1;
          cmd.clrSlave = sHas;
          cmd.spurious = !sHas;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vecValid <= 1'b0;
    else        vecValid <= ack;
  end
endmodule

// File: rtl/cascade_dp.sv
module cascade_dp
  import cascade_vector_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  parameter logic [LINES-1:0] MASTER_MASK = 'hF8,
  parameter logic [LINES-1:0] SLAVE_MASK = 'hDE,
  localparam int IW = $clog2(LINES),
  localparam int BASE_W = VEC_W - IW,
  localparam int ALL = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALL-1:0]    irqLines,
  input  logic [BASE_W-1:0] masterBase,
  input  logic [BASE_W-1:0] slaveBase,
  input  logic              trigWr,
  input  logic              trigSel,
  input  logic [LINES-1:0]  trigData,
  input  ackCmd_t           cmd,
  output logic              mHas,
  output logic [IW-1:0]     mWin,
  output logic              sHas,
  output logic              cpuInt,
  output logic [VEC_W-1:0]  vector,
  output logic [LINES-1:0]  trigMaster,
  output logic [LINES-1:0]  trigSlave
);
  logic [ALL-1:0]   lastLine;
  logic [ALL-1:0]   pendAll;
  logic [ALL-1:0]   clrVec;
  logic [ALL-1:0]   trigAll;
  logic [LINES-1:0] masterReq;
  logic [IW-1:0]    sWin;
  logic             casc;
  logic [IW-1:0]    vecIdx;
  logic [BASE_W-1:0] vecBase;

  assign trigAll = {trigSlave, trigMaster};

  // master input at the cascade position also carries the slave flag
  always_comb begin
    masterReq = pendAll[LINES-1:0];
    masterReq[CASC_LINE] = pendAll[CASC_LINE] | casc;
  end

  cascade_resolver #(.WIDTH(LINES)) mRes (
    .req(masterReq), .hasWin(mHas), .win(mWin)
  );
  cascade_resolver #(.WIDTH(LINES)) sRes (
    .req(pendAll[ALL-1:LINES]), .hasWin(sHas), .win(sWin)
  );

  always_comb begin
    clrVec = '0;
    if (cmd.clrMaster) clrVec[{1'b0, mWin}] = 1'b1;
    if (cmd.clrSlave)  clrVec[{1'b1, sWin}] = 1'b1;
  end

  for (genvar g = 0; g < ALL; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n)
        pendAll[g] <= 1'b0;
      else if (trigAll[g])
        pendAll[g] <= irqLines[g];
      else
        pendAll[g] <= (pendAll[g] & ~clrVec[g]) | (irqLines[g] & ~lastLine[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastLine   <= '0;
      casc       <= 1'b0;
      trigMaster <= '0;
      trigSlave  <= '0;
    end else begin
      lastLine <= irqLines;
      casc     <= |pendAll[ALL-1:LINES];
      if (trigWr) begin
        if (trigSel) trigSlave  <= trigData & SLAVE_MASK;
        else         trigMaster <= trigData & MASTER_MASK;
      end
    end
  end

  assign vecIdx  = cmd.spurious ? IW'(LINES - 1) : (cmd.useSlave ? sWin : mWin);
  assign vecBase = cmd.useSlave ? slaveBase : masterBase;

  always_ff @(posedge clk) begin
    if (!rst_n)           vector <= '0;
    else if (cmd.loadVec) vector <= {vecBase, vecIdx};
  end

  assign cpuInt = mHas;
endmodule

// File: rtl/cascade_vector_gen.sv
module cascade_vector_gen
  import cascade_vector_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  parameter logic [LINES-1:0] MASTER_MASK = 'hF8,
  parameter logic [LINES-1:0] SLAVE_MASK = 'hDE,
  localparam int IW = $clog2(LINES),
  localparam int BASE_W = VEC_W - IW,
  localparam int ALL = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALL-1:0]    irqLines,
  input  logic [BASE_W-1:0] masterBase,
  input  logic [BASE_W-1:0] slaveBase,
  input  logic              ack,
  input  logic              trigWr,
  input  logic              trigSel,
  input  logic [LINES-1:0]  trigData,
  output logic              cpuInt,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vector,
  output logic [LINES-1:0]  trigMaster,
  output logic [LINES-1:0]  trigSlave
);
  ackCmd_t       cmd;
  logic          mHas;
  logic [IW-1:0] mWin;
  logic          sHas;

  cascade_ctrl #(.LINES(LINES), .CASC_LINE(CASC_LINE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ack(ack),
    .mHas(mHas), .mWin(mWin), .sHas(sHas),
    .cmd(cmd), .vecValid(vecValid)
  );

  cascade_dp #(
    .LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE),
    .MASTER_MASK(MASTER_MASK), .SLAVE_MASK(SLAVE_MASK)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines),
    .masterBase(masterBase), .slaveBase(slaveBase),
    .trigWr(trigWr), .trigSel(trigSel), .trigData(trigData),
    .cmd(cmd), .mHas(mHas), .mWin(mWin), .sHas(sHas),
    .cpuInt(cpuInt), .vector(vector),
    .trigMaster(trigMaster), .trigSlave(trigSlave)
  );
endmodule

// File: rtl/cascade_vector_chk.sv
module cascade_vector_chk #(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter logic [LINES-1:0] MASTER_MASK = 'hF8,
  parameter logic [LINES-1:0] SLAVE_MASK = 'hDE,
  localparam int IW = $clog2(LINES),
  localparam int BASE_W = VEC_W - IW
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BASE_W-1:0] masterBase,
  input logic [BASE_W-1:0] slaveBase,
  input logic              ack,
  input logic              trigWr,
  input logic              trigSel,
  input logic [LINES-1:0]  trigData,
  input logic              cpuInt,
  input logic              vecValid,
  input logic [VEC_W-1:0]  vector,
  input logic [LINES-1:0]  trigMaster,
  input logic [LINES-1:0]  trigSlave
);
  // R6
  ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vecValid);
  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vecValid);
  // R7
  spurious_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cpuInt) |=> (vector == {$past(masterBase), IW'(LINES - 1)}));
  // R2
  vector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cpuInt) |=> (vector[VEC_W-1:IW] == $past(masterBase) ||
                         vector[VEC_W-1:IW] == $past(slaveBase)));
  // R11
  master_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trigWr && !trigSel) |=> (trigMaster == ($past(trigData) & MASTER_MASK)));
  // R11
  slave_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trigWr && trigSel) |=> (trigSlave == ($past(trigData) & SLAVE_MASK)));
endmodule

bind cascade_vector_gen cascade_vector_chk #(
  .LINES(LINES), .VEC_W(VEC_W),
  .MASTER_MASK(MASTER_MASK), .SLAVE_MASK(SLAVE_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .masterBase(masterBase), .slaveBase(slaveBase),
  .ack(ack), .trigWr(trigWr), .trigSel(trigSel), .trigData(trigData),
  .cpuInt(cpuInt), .vecValid(vecValid), .vector(vector),
  .trigMaster(trigMaster), .trigSlave(trigSlave)
);

// File: tb/cascade_vector_gen_tb_top.sv
`timescale 1ns/1ps
module cascade_vector_gen_tb_top;
  localparam logic [4:0] MB = 5'h01;
  localparam logic [4:0] SB = 5'h0E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irqLines = '0;
  logic        ack = 1'b0;
  logic        trigWr = 1'b0;
  logic        trigSel = 1'b0;
  logic [7:0]  trigData = '0;
  logic        cpuInt, vecValid;
  logic [7:0]  vector, trigMaster, trigSlave;

  int passCnt = 0;
  int totalCnt = 0;

  always #2.5 clk = ~clk;

  cascade_vector_gen dut_i (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines),
    .masterBase(MB), .slaveBase(SB), .ack(ack),
    .trigWr(trigWr), .trigSel(trigSel), .trigData(trigData),
    .cpuInt(cpuInt), .vecValid(vecValid), .vector(vector),
    .trigMaster(trigMaster), .trigSlave(trigSlave)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] vecOf(input int n);
    return (n < 8) ? {MB, 3'(n)} : {SB, 3'(n)};
  endfunction

  // priority key: master lines by index, slave group sits at the cascade slot
  function automatic int keyOf(input int n);
    return (n < 8) ? n * 16 : 32 + (n - 8);
  endfunction

  task automatic doAck(input logic [7:0] exp, input string tag);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk(vecValid == 1'b1, {tag, " R6 valid"}, vecValid, 1);
    chk(vector == exp, {tag, " vector"}, vector, exp);
    tick(1);
    chk(vecValid == 1'b0, {tag, " R6 valid drop"}, vecValid, 0);
  endtask

  task automatic writeTrig(input logic sel, input logic [7:0] d);
    trigWr = 1'b1; trigSel = sel; trigData = d;
    tick(1);
    trigWr = 1'b0;
  endtask

  task automatic pulse2(input int a, input int b);
    irqLines[a] = 1'b1; irqLines[b] = 1'b1;
    tick(1);
    irqLines[a] = 1'b0; irqLines[b] = 1'b0;
    tick(3);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk(cpuInt == 1'b0, "R1 cpuInt", cpuInt, 0);
    chk(vecValid == 1'b0, "R1 vecValid", vecValid, 0);
    chk(trigMaster == 8'h00 && trigSlave == 8'h00, "R1 trig", {trigSlave, trigMaster}, 0);

    // R7: nothing pending
    doAck({MB, 3'd7}, "R7 empty");
    chk(cpuInt == 1'b0, "R7 cpuInt", cpuInt, 0);

    // R2 R5 R9: each line alone, edge triggered
    for (int i = 0; i < 16; i++) begin
      if (i == 2) continue;
      pulse2(i, i);
      chk(cpuInt == 1'b1, $sformatf("R5 line %0d raise", i), cpuInt, 1);
      doAck(vecOf(i), $sformatf("R2 line %0d", i));
      chk(cpuInt == 1'b0, $sformatf("R9 line %0d cleared", i), cpuInt, 0);
    end

    // R4: every pair of lines, winner then loser then empty
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        if (i == 2 || j == 2) continue;
        pulse2(i, j);
        if (keyOf(i) < keyOf(j)) begin
          doAck(vecOf(i), $sformatf("R4 pair %0d,%0d first", i, j));
          chk(cpuInt == 1'b1, "R5 second pending", cpuInt, 1);
          doAck(vecOf(j), $sformatf("R4 pair %0d,%0d second", i, j));
        end else begin
          doAck(vecOf(j), $sformatf("R4 pair %0d,%0d first", i, j));
          chk(cpuInt == 1'b1, "R5 second pending", cpuInt, 1);
          doAck(vecOf(i), $sformatf("R4 pair %0d,%0d second", i, j));
        end
        chk(cpuInt == 1'b0, "R5 pair drained", cpuInt, 0);
      end
    end

    // R3 R8: external line 2 alone lands on an empty slave
    pulse2(2, 2);
    chk(cpuInt == 1'b1, "R3 line2 raises", cpuInt, 1);
    doAck({SB, 3'd7}, "R8 slave spurious");
    chk(cpuInt == 1'b0, "R8 line2 cleared", cpuInt, 0);

    // R3: line 2 together with slave line 9 routes to the slave winner
    pulse2(2, 9);
    doAck(vecOf(9), "R3 line2 with 9");
    chk(cpuInt == 1'b0, "R3 both cleared", cpuInt, 0);

    // R9: level line 5 is not cleared by acknowledge
    writeTrig(1'b0, 8'h20);
    chk(trigMaster == 8'h20, "R11 master write", trigMaster, 8'h20);
    irqLines[5] = 1'b1;
    tick(3);
    doAck(vecOf(5), "R9 level first");
    chk(cpuInt == 1'b1, "R9 level held", cpuInt, 1);
    doAck(vecOf(5), "R9 level second");
    irqLines[5] = 1'b0;
    tick(2);
    chk(cpuInt == 1'b0, "R9 level released", cpuInt, 0);

    // R11: masks and forced-edge lines
    writeTrig(1'b0, 8'hFF);
    chk(trigMaster == 8'hF8, "R11 master mask", trigMaster, 8'hF8);
    writeTrig(1'b1, 8'hFF);
    chk(trigSlave == 8'hDE, "R11 slave mask", trigSlave, 8'hDE);
    irqLines[0] = 1'b1;
    tick(3);
    doAck(vecOf(0), "R11 line0");
    chk(cpuInt == 1'b0, "R11 line0 stays edge", cpuInt, 0);
    irqLines[8] = 1'b1;
    tick(3);
    doAck(vecOf(8), "R11 line8");
    chk(cpuInt == 1'b0, "R11 line8 stays edge", cpuInt, 0);
    irqLines[0] = 1'b0; irqLines[8] = 1'b0;
    writeTrig(1'b0, 8'h00);
    writeTrig(1'b1, 8'h00);
    chk(trigMaster == 8'h00 && trigSlave == 8'h00, "R11 cleared", {trigSlave, trigMaster}, 0);
    tick(2);

    // R10: new edge on line 4 in the acknowledge cycle
    pulse2(4, 4);
    irqLines[4] = 1'b1;
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    irqLines[4] = 1'b0;
    chk(vector == vecOf(4), "R10 vector", vector, vecOf(4));
    tick(1);
    chk(cpuInt == 1'b1, "R10 still pending", cpuInt, 1);
    doAck(vecOf(4), "R10 second ack");
    chk(cpuInt == 1'b0, "R10 drained", cpuInt, 0);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule